// File: doc/BRIEF.md
# Dual-Mode Heartbeat Watchdog

This block supervises a processor by watching a single heartbeat line. Every change of level on that line, rising or falling, counts as service and restarts the timer. If the timer runs a full window without service, the block drives an active-low fault output. The fault can be looped back to the system reset or read as a plain alarm.

There are two window lengths. A long window applies after power-up, after a system reset and after an expiry. It gives boot code time before the first heartbeat. A short window, 1/64 of the long one, applies once a service edge has been seen.

A configuration input turns the watchdog off. A freeze input holds it in place while supplies are being margined. The heartbeat is brought into the clock domain through a two-flop synchroniser before edge detection. Window lengths are given in clock cycles by parameters.

Top module: `hb_watchdog`

## Requirements
- R1: While `rst_ni` is low, `fault_no` is 1, the timer is cleared and the long window is selected. After release, the heartbeat line is taken to have been 0 before reset, so a line already at 1 counts as one service edge.
- R2: `hb_i` passes through two synchronising flops. A level change set up before rising clock edge k takes effect at edge k+2, which is the third rising edge.
- R3: With the long window selected and no service, `fault_no` falls on the (64*NORM_CYCLES)-th rising edge at which the timer counts. After reset release, that is counted from the first rising edge.
- R4: A service edge of either polarity clears the timer, selects the short window and releases `fault_no` to 1 at the edge where it takes effect. Two back-to-back edges from a one-cycle pulse each count.
- R5: With the short window selected, `fault_no` falls on the NORM_CYCLES-th rising edge after the edge at which the last service took effect.
- R6: After an expiry, `fault_no` stays 0 and the timer stays stopped until the next service edge. The expiry also reselects the long window.
- R7: While `sys_rst_i` is 1 and the block is not frozen, the following hold:
  - `fault_no` is released to 1 on the next edge.
  - The timer is held at zero.
  - Service edges are discarded.
  - The long window is selected, so after release the R3 timing applies even if the short window was active before.
- R8: While `wd_dis_i` is 1, `fault_no` is 1 from the next edge, the timer is cleared and the long window is selected. This overrides freeze and system reset.
- R9: While `freeze_ni` is 0 and `wd_dis_i` is 0, the timer count, the window selection and `fault_no` all hold. Service edges and `sys_rst_i` seen during the freeze are discarded. Counting resumes from the held count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| sys_rst_i | input | 1 | System reset, active high; clears and holds the timer |
| hb_i | input | 1 | Heartbeat from the supervised processor, asynchronous |
| wd_dis_i | input | 1 | Watchdog disable, active high |
| freeze_ni | input | 1 | Freeze, active low; holds the state and the output |
| fault_no | output | 1 | Watchdog fault, active low |

## Verification
The hardest state to reach is a window that is partly consumed and then frozen, followed by a resume. Only the exact cycle of the late expiry shows that the count was held rather than cleared. The stimulus services the block, lets five cycles pass, freezes it for far longer than a short window, then unfreezes it and checks that the fault falls on the fifteenth edge. A second hard case is the two edges produced by a one-cycle heartbeat pulse. The expiry cycle shows whether the second edge was seen, so the check is placed one cycle past where a single edge would expire.

// File: rtl/hb_watchdog_pkg.sv
package hb_watchdog_pkg;
  typedef enum logic {
    WIN_LONG  = 1'b0,
    WIN_SHORT = 1'b1
  } win_sel_e;
endpackage

// File: rtl/hb_sync_edge.sv
module hb_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hb_i,
  output logic edge_o
);
  localparam int unsigned W = STAGES + 1;

  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[W-2:0], hb_i};
  end

  // last stage is the previous synchronised level
  assign edge_o = sr_q[W-1] ^ sr_q[W-2];
endmodule

// File: rtl/hb_wd_timer.sv
module hb_wd_timer
  import hb_watchdog_pkg::*;
#(
  parameter longint unsigned NORM_CYCLES = 80_000_000,
  parameter int unsigned     INIT_MULT   = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic svc_i,
  input  logic dis_i,
  input  logic frz_ni,
  input  logic srst_i,
  output logic fault_o
);
  localparam longint unsigned INIT_CYCLES = NORM_CYCLES * INIT_MULT;
  localparam int unsigned     CW          = $clog2(INIT_CYCLES);

  win_sel_e        win_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   last_v;

  assign last_v = (win_q == WIN_SHORT) ? CW'(NORM_CYCLES - 1) : CW'(INIT_CYCLES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      win_q   <= WIN_LONG;
      fault_o <= 1'b0;
    end else if (dis_i || (frz_ni && srst_i)) begin
      cnt_q   <= '0;
      win_q   <= WIN_LONG;
      fault_o <= 1'b0;
    end else if (!frz_ni) begin
      // hold everything
    end else if (svc_i) begin
      cnt_q   <= '0;
      win_q   <= WIN_SHORT;
      fault_o <= 1'b0;
    end else if (fault_o) begin
      // expired: wait for service
    end else if (cnt_q == last_v) begin
      cnt_q   <= '0;
      win_q   <= WIN_LONG;
      fault_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter longint unsigned NORM_CYCLES = 80_000_000,
  parameter int unsigned     INIT_MULT   = 64,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic hb_i,
  input  logic wd_dis_i,
  input  logic freeze_ni,
  output logic fault_no
);
  logic svc_edge;
  logic fault;

  hb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hb_i   (hb_i),
    .edge_o (svc_edge)
  );

  hb_wd_timer #(.NORM_CYCLES(NORM_CYCLES), .INIT_MULT(INIT_MULT)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .svc_i   (svc_edge),
    .dis_i   (wd_dis_i),
    .frz_ni  (freeze_ni),
    .srst_i  (sys_rst_i),
    .fault_o (fault)
  );

  assign fault_no = ~fault;
endmodule

// File: rtl/hb_watchdog_chk.sv
module hb_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sys_rst_i,
  input logic wd_dis_i,
  input logic freeze_ni,
  input logic svc_edge_i,
  input logic fault_no
);
  // R8
  dis_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_dis_i |=> fault_no);

  // R7
  srst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && freeze_ni) |=> fault_no);

  // R9
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_ni && !wd_dis_i) |=> $stable(fault_no));

  // R4
  service_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_edge_i && freeze_ni) |=> fault_no);

  // R6
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_no && !svc_edge_i && !wd_dis_i && !sys_rst_i) |=> !fault_no);

  // R3
  fault_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_no) |-> $past(freeze_ni && !wd_dis_i && !sys_rst_i && !svc_edge_i));
endmodule

bind hb_watchdog hb_watchdog_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sys_rst_i  (sys_rst_i),
  .wd_dis_i   (wd_dis_i),
  .freeze_ni  (freeze_ni),
  .svc_edge_i (svc_edge),
  .fault_no   (fault_no)
);

// File: tb/sim_hb_watchdog.sv
`timescale 1ns/1ps
module sim_hb_watchdog;
  localparam int NORM = 20;
  localparam int LONG = NORM * 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sys_rst_i = 1'b0;
  logic hb_i = 1'b0;
  logic wd_dis_i = 1'b0;
  logic freeze_ni = 1'b1;
  logic fault_no;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hb_watchdog #(.NORM_CYCLES(NORM), .INIT_MULT(64), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .hb_i(hb_i),
    .wd_dis_i(wd_dis_i), .freeze_ni(freeze_ni), .fault_no(fault_no)
  );

  // behavioural reference: sample history, idle count, window flag, fault flag
  bit hist[$];
  int m_cnt;
  bit m_short;
  bit m_flt;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{1'b0, 1'b0, 1'b0};
      m_cnt = 0; m_short = 0; m_flt = 0;
    end else begin
      bit svc;
      int lim;
      svc = (hist[1] != hist[2]);
      hist.push_front(hb_i);
      void'(hist.pop_back());
      lim = m_short ? NORM : LONG;
      if (wd_dis_i || (freeze_ni && sys_rst_i)) begin
        m_cnt = 0; m_short = 0; m_flt = 0;
      end else if (!freeze_ni) begin
      end else if (svc) begin
        m_cnt = 0; m_short = 1; m_flt = 0;
      end else if (m_flt) begin
      end else if (m_cnt == lim - 1) begin
        m_cnt = 0; m_short = 0; m_flt = 1;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    checks++;
    if (fault_no !== !m_flt) begin
      fails++;
      $display("FAIL model cycle %0d (R2 R3 R5 timing): fault_no=%b expected=%b", cyc, fault_no, !m_flt);
    end
  end

  task automatic chk(input string tag, input logic exp);
    checks++;
    if (fault_no !== exp) begin
      fails++;
      $display("FAIL %s: fault_no=%b expected=%b", tag, fault_no, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle();
    hb_i = ~hb_i;
  endtask

  initial begin
    step(3);
    chk("R1 reset", 1'b1);
    rst_ni = 1'b1;
    // R3 long window from reset release
    step(LONG - 1); chk("R3 before long expiry", 1'b1);
    step(1);        chk("R3 long expiry", 1'b0);
    // R6 sticky fault
    step(50);       chk("R6 fault held", 1'b0);
    // R2 R4 rising edge releases on third edge
    toggle();
    step(2);        chk("R2 not yet synced", 1'b0);
    step(1);        chk("R4 rising edge release", 1'b1);
    // R4 R5 regular service, both polarities
    for (int i = 0; i < 6; i++) begin
      step(15); toggle();
      chk("R4 serviced", 1'b1);
    end
    step(NORM + 2); chk("R5 before short expiry", 1'b1);
    step(1);        chk("R5 short expiry", 1'b0);
    // R4 one-cycle pulse gives two edges
    toggle(); step(1); toggle();
    step(2);        chk("R4 pulse release", 1'b1);
    step(20);       chk("R4 second pulse edge counted", 1'b1);
    step(1);        chk("R5 expiry after pulse", 1'b0);
    // R7 system reset: enter short window then reset
    toggle(); step(5); chk("R4 release before sys reset", 1'b1);
    sys_rst_i = 1'b1;
    step(1);        chk("R7 held", 1'b1);
    for (int i = 0; i < 300; i++) begin
      step(5); toggle();
    end
    step(5);
    chk("R7 no fault while in reset", 1'b1);
    sys_rst_i = 1'b0;
    step(LONG - 1); chk("R7 long window after reset", 1'b1);
    step(1);        chk("R7 long expiry after reset", 1'b0);
    // R8 disable
    wd_dis_i = 1'b1;
    step(1);        chk("R8 disable releases", 1'b1);
    step(1500);     chk("R8 disabled stays inactive", 1'b1);
    wd_dis_i = 1'b0;
    step(LONG - 1); chk("R8 long window after enable", 1'b1);
    step(1);        chk("R8 expiry after enable", 0);
    // R9 freeze discards edges and sys reset
    freeze_ni = 1'b0;
    toggle(); step(4);
    sys_rst_i = 1'b1; step(2); sys_rst_i = 1'b0;
    step(10);       chk("R9 frozen fault held", 1'b0);
    freeze_ni = 1'b1;
    step(5);        chk("R9 frozen edge discarded", 1'b0);
    toggle();
    step(3);        chk("R4 release after freeze", 1'b1);
    step(5);
    freeze_ni = 1'b0;
    step(100);      chk("R9 count held", 1'b1);
    freeze_ni = 1'b1;
    step(14);       chk("R9 resumed count", 1'b1);
    step(1);        chk("R9 resumed expiry", 1'b0);
    // R8 disable overrides freeze
    freeze_ni = 1'b0; wd_dis_i = 1'b1;
    step(1);        chk("R8 disable over freeze", 1'b1);
    wd_dis_i = 1'b0; freeze_ni = 1'b1;
    step(3);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 200000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, done=%b expected=1", done);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule